// File: doc/BRIEF.md
# Register Access Workaround Sequencer

This block sits between a single-request register port and a downstream register bus whose target can hang on certain access patterns. For every request it emits, one at a time, an optional guard read before the real access, the real access itself, and one or two guard reads after it. The guard reads go to fixed offsets chosen by decoding the requested offset. Their data is discarded.

The guarding is active only when a strap says the target is the defective revision and the requested offset falls below a fixed limit. Otherwise the request passes through as a single downstream access. The requester receives a one-cycle completion carrying the read data of the real access.

Top module: `mmr_detour_seq`

## Requirements
- R1: With `rev_affected` low when a request is accepted, exactly one downstream access is made: the requested offset, direction and write data. The strap is sampled only at acceptance.
- R2: With `rev_affected` high, offsets of 0x45000 and above pass through as a single access. Offsets up to 0x44FFF are guarded, for example 0x44FF8.
- R3: A guarded request to offset 0x0 or 0x80 is preceded by a read of 0xC0. A guarded request to offset 0x148 or 0x200 is preceded by a read of 0x28.
- R4: Any other guarded offset is preceded by a read of 0x158.
- R5: After the real access, a guarded request to 0x100 is followed by a read of 0x38 and then a read of 0xB050. Every other guarded request is followed by a read of 0xB050 only.
- R6: Guard accesses are always reads (`bus_write` low). Only the real access carries the request's direction and `bus_wdata`.
- R7: `req_ready` is high only when no downstream access is pending. A request is accepted on `req_valid && req_ready`. `rsp_valid` pulses for one cycle, in the cycle after the handshake of the last downstream access, and a new request may be accepted in that same cycle.
- R8: `rsp_rdata` equals the data returned by the real read access and never guard-read data. It is zero for a completed write.
- R9: Each downstream access holds `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` steady until `bus_ready`. The next access is issued only after that handshake, so the order is guard-before, real, guard-after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rev_affected | input | 1 | Strap: target is the defective revision |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | AW | Register offset relative to block base |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Real-access read data, zero for writes |
| bus_valid | output | 1 | Downstream access pending |
| bus_ready | input | 1 | Downstream access accepted and complete |
| bus_write | output | 1 | Downstream direction |
| bus_addr | output | AW | Downstream offset |
| bus_wdata | output | DW | Downstream write data |
| bus_rdata | input | DW | Downstream read data, valid with `bus_ready` |

## Verification
The completion pulse of one request and the acceptance of the next can fall in the same cycle. The bench provokes this on every request of its sweep by raising the next `req_valid` in the very cycle `rsp_valid` is seen. It then judges both sides independently. The finished request must report the real-access data. The new request's full downstream beat list must match the decode computed in the bench, with nothing dropped or duplicated at the seam. The downstream model varies its `bus_ready` latency from beat to beat, so the hold-until-handshake behaviour is exercised along the way.

// File: rtl/mmr_detour_seq.sv
module mmr_detour_seq #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter logic [AW-1:0] GUARD_LIMIT = AW'(32'h45000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rev_affected,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_offset,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  localparam logic [AW-1:0] OFF_A0   = AW'(32'h000);
  localparam logic [AW-1:0] OFF_A1   = AW'(32'h080);
  localparam logic [AW-1:0] OFF_B0   = AW'(32'h148);
  localparam logic [AW-1:0] OFF_B1   = AW'(32'h200);
  localparam logic [AW-1:0] OFF_TAIL = AW'(32'h100);
  localparam logic [AW-1:0] PRE_A    = AW'(32'h0C0);
  localparam logic [AW-1:0] PRE_B    = AW'(32'h028);
  localparam logic [AW-1:0] PRE_C    = AW'(32'h158);
  localparam logic [AW-1:0] POST_X   = AW'(32'h038);
  localparam logic [AW-1:0] POST_Y   = AW'(32'hB050);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_REAL, S_POSTX, S_POSTY} st_t;

  st_t           st;
  logic [AW-1:0] off_q;
  logic          wr_q;
  logic [DW-1:0] wd_q;
  logic          hit_q;
  logic [AW-1:0] pre_addr;

  wire req_fire = req_valid && req_ready;
  wire hs       = bus_valid && bus_ready;
  wire hit_now  = rev_affected && (req_offset < GUARD_LIMIT);

  always_comb begin
    if (off_q == OFF_A0 || off_q == OFF_A1)      pre_addr = PRE_A;
    else if (off_q == OFF_B0 || off_q == OFF_B1) pre_addr = PRE_B;
    else                                         pre_addr = PRE_C;
  end

  always_comb begin
    case (st)
      S_PRE:   bus_addr = pre_addr;
      S_POSTX: bus_addr = POST_X;
      S_POSTY: bus_addr = POST_Y;
      default: bus_addr = off_q;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign bus_valid = (st != S_IDLE);
  assign bus_write = (st == S_REAL) && wr_q;
  assign bus_wdata = bus_write ? wd_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      off_q     <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      hit_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_fire) begin
          off_q <= req_offset;
          wr_q  <= req_write;
          wd_q  <= req_wdata;
          hit_q <= hit_now;
          st    <= hit_now ? S_PRE : S_REAL;
        end
        S_PRE: if (hs) st <= S_REAL;
        S_REAL: if (hs) begin
          rsp_rdata <= wr_q ? '0 : bus_rdata;
          if (!hit_q) begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
          end else begin
            st <= (off_q == OFF_TAIL) ? S_POSTX : S_POSTY;
          end
        end
        S_POSTX: if (hs) st <= S_POSTY;
        S_POSTY: if (hs) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PASS_REV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !rev_affected) |=> (bus_valid && bus_addr == $past(req_offset))); // R1
  AST_PASS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_offset >= GUARD_LIMIT) |=> (bus_valid && bus_addr == $past(req_offset))); // R2
  AST_PRE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && rev_affected && (req_offset == OFF_A0 || req_offset == OFF_A1)) |=> (bus_addr == PRE_A && !bus_write)); // R3
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready); // R7
  AST_RSP_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(bus_valid && bus_ready)); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))); // R9
  AST_GUARD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_addr == POST_Y) && (off_q != POST_Y)) |-> !bus_write); // R6

endmodule

// File: tb/mmr_detour_seq_bench.sv
module mmr_detour_seq_bench;
  localparam int AW = 20;
  localparam int DW = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          rev_affected = 0;
  logic          req_valid = 0;
  logic          req_ready;
  logic          req_write = 0;
  logic [AW-1:0] req_offset = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          bus_valid;
  logic          bus_ready;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;

  mmr_detour_seq #(.AW(AW), .DW(DW)) u_mmr_detour_seq (
    .clk(clk), .rst_n(rst_n), .rev_affected(rev_affected),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [AW-1:0] log_addr [0:7];
  logic          log_wr   [0:7];
  logic [DW-1:0] log_wd   [0:7];
  int            log_n = 0;
  int            gseq = 0;
  int            wait_c = 0;
  logic          busy_ready_seen = 0;

  function automatic logic [DW-1:0] dat(input logic [AW-1:0] a);
    return {a, 12'h5C3};
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    bus_ready = 0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (bus_valid && req_ready) busy_ready_seen = 1;
      if (bus_ready) begin
        bus_ready = 0;
      end else if (bus_valid && rst_n) begin
        if (wait_c >= gseq % 3) begin
          bus_ready = 1;
          bus_rdata = dat(bus_addr);
          if (log_n < 8) begin
            log_addr[log_n] = bus_addr;
            log_wr[log_n]   = bus_write;
            log_wd[log_n]   = bus_wdata;
          end
          log_n++;
          wait_c = 0;
          gseq++;
        end else begin
          wait_c++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected <100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  logic [AW-1:0] offs [0:11];
  initial begin
    offs[0] = 20'h00000; offs[1] = 20'h00080; offs[2] = 20'h00148; offs[3] = 20'h00200;
    offs[4] = 20'h00100; offs[5] = 20'h00158; offs[6] = 20'h44FF8; offs[7] = 20'h45000;
    offs[8] = 20'h45008; offs[9] = 20'hFFFF8; offs[10] = 20'h00038; offs[11] = 20'h01000;
  end

  task automatic run_case(input logic rev, input logic wr, input logic [AW-1:0] off, input logic [DW-1:0] wd);
    logic [AW-1:0] ea [0:3];
    int en;
    int real_i;
    int t;
    logic hit;
    hit = rev && (off < 20'h45000);
    en = 0;
    real_i = 0;
    if (hit) begin
      if (off == 20'h0 || off == 20'h80) ea[en] = 20'h000C0;
      else if (off == 20'h148 || off == 20'h200) ea[en] = 20'h00028;
      else ea[en] = 20'h00158;
      en++;
    end
    real_i = en;
    ea[en] = off; en++;
    if (hit) begin
      if (off == 20'h100) begin ea[en] = 20'h00038; en++; end
      ea[en] = 20'h0B050; en++;
    end
    log_n = 0;
    busy_ready_seen = 0;
    rev_affected = rev;
    req_write = wr;
    req_offset = off;
    req_wdata = wd;
    req_valid = 1;
    chk("R7", "ready at issue", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 0;
    rev_affected = ~rev;
    req_offset = ~off;
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    chk("R7", "completion seen", {31'b0, rsp_valid}, 32'd1);
    chk("R7", "ready with completion", {31'b0, req_ready}, 32'd1);
    chk("R7", "no ready while busy", {31'b0, busy_ready_seen}, 32'd0);
    chk(hit ? "R5" : (rev ? "R2" : "R1"), "beat count", log_n, en);
    for (int i = 0; i < en && i < log_n && i < 8; i++) begin
      if (i == real_i) begin
        chk(rev ? "R2" : "R1", "real addr", {12'b0, log_addr[i]}, {12'b0, off});
        chk("R6", "real dir", {31'b0, log_wr[i]}, {31'b0, wr});
        if (wr) chk("R6", "real wdata", log_wd[i], wd);
      end else begin
        chk(i < real_i ? ((ea[i] == 20'h158) ? "R4" : "R3") : "R5", "guard addr", {12'b0, log_addr[i]}, {12'b0, ea[i]});
        chk("R6", "guard is read", {31'b0, log_wr[i]}, 32'd0);
      end
    end
    chk("R8", "rsp data", rsp_rdata, wr ? 32'd0 : dat(off));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7", "reset ready", {31'b0, req_ready}, 32'd1);
    chk("R9", "reset bus idle", {31'b0, bus_valid}, 32'd0);
    chk("R7", "reset rsp", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 12; k++)
          run_case(r[0], w[0], offs[k], 32'hD000_0000 | (k * 16 + w * 4 + r));
    @(negedge clk);
    chk("R7", "rsp pulse ends", {31'b0, rsp_valid}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule